// File: doc/BRIEF.md
# HDLC Receive Deframer

This block turns a serial HDLC line into a stream of payload bytes. Each line bit comes with a one-cycle strobe. A small line monitor watches runs of ones to find flags, aborts, go-ahead patterns and idle line. It also removes the zeros that the transmitter inserted. The surviving data bits are packed into bytes, least significant bit first, and handed to a downstream FIFO over a valid/ready port. Each frame ends with one tagged end-of-packet item.

The end-of-packet item tells the consumer how the frame ended: a clean close, an abort, or a close that left a partial byte. It carries no CRC or address status. A set of one-cycle event pulses mirrors what happened on the line, so an interrupt block can use them.

An enable input brings the receiver up and down. After enable, the receiver does nothing until it sees a flag. When enable is removed, the receiver stops at a packet boundary, or at once if it has not yet written a byte of the current packet. A transparent mode skips every protocol function and packs raw line bits into bytes.

The output port follows valid/ready rules. An item stays presented, unchanged, until the consumer takes it, and the consumer may hold ready low for as long as it likes. The line cannot be stalled, so a write that meets a full output slot is an overflow. In protocol mode, the item is dropped and the receiver hunts for a flag. In transparent mode, the new byte replaces the held one.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While reset is asserted and on release, item_valid, line_idle and all five event pulses are low.
- R2: The bit sequence 0,1,1,1,1,1,1,0 on strobed bits is a flag and raises flag_pulse for one cycle. A 0 that follows five consecutive ones is removed. Payload bytes appear on item_data in arrival order with the first data bit in bit 0, and with item_eop=0 and item_kind=00.
- R3: A flag that closes a frame holding a whole number of bytes (at least one data bit) writes an item with item_eop=1, item_kind=00 and item_data=0. eopd_pulse rises in the cycle that item appears. A flag with no data bits since the previous flag writes nothing.
- R4: A closing flag that leaves a partial byte writes an end item with item_kind=10. The partial bits are discarded.
- R5: Seven consecutive ones end the frame as an abort. Bytes completed before the last data bit are forwarded, then an end item with item_kind=01. abort_pulse is raised together with eopd_pulse only if at least 26 data bits (after zero removal) came before the run of ones. The receiver then waits for a flag.
- R6: The pattern 0,1,1,1,1,1,1,1,0 raises goahead_pulse for one cycle.
- R7: line_idle goes high after fifteen consecutive ones and low after the next 0.
- R8: After rx_enable rises, no item and no pulse is produced until a flag is seen. A frame already in progress when the receiver is enabled is discarded.
- R9: When rx_enable is low and the current frame has already written a byte, the frame completes and its end item is written before the receiver stops. When no byte of the frame has been written, the receiver stops at once and the frame is lost. A stopped receiver produces no items and no pulses.
- R10: An item is transferred on a cycle with item_valid and item_ready both high. While item_ready is low, item_valid stays high, and in protocol mode item_data, item_eop and item_kind stay unchanged.
- R11: In protocol mode, a write that finds the output slot full and not being drained is dropped and raises overflow_pulse. The held item is kept, and no further items are written until the next flag.
- R12: With transparent high, every strobed bit enters the byte packer with no flag, abort, go-ahead or zero removal. The first bit after the mode change becomes bit 0, and no flag_pulse fires. An overflow replaces the held byte with the new one and raises overflow_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receiver enable |
| transparent | input | 1 | Raw byte mode, no protocol processing |
| line_bit | input | 1 | Serial line data |
| line_bit_en | input | 1 | One-cycle strobe marking a valid line_bit |
| item_valid | output | 1 | Output item present |
| item_ready | input | 1 | Consumer accepts the item |
| item_data | output | 8 | Payload byte, zero on end items |
| item_eop | output | 1 | Item is an end-of-packet marker |
| item_kind | output | 2 | End kind: 00 clean, 01 abort, 10 partial byte |
| flag_pulse | output | 1 | Flag detected |
| goahead_pulse | output | 1 | Go-ahead pattern detected |
| abort_pulse | output | 1 | Frame abort after the minimum length |
| eopd_pulse | output | 1 | End-of-packet item written |
| overflow_pulse | output | 1 | Write met a full output slot |
| line_idle | output | 1 | Fifteen or more consecutive ones |

## Verification
Some behaviour is checked on every cycle. These checks cover holding the output while it is back-pressured and keeping item fields stable. They also cover the timing between eopd_pulse, abort_pulse and the end item they describe, overflow happening only with a held item, and line_idle rising only on a strobed one. Other behaviour needs planned line sequences in the bench scenarios, because it depends on long bit histories. This includes byte content and zero removal, the 25-bit versus 26-bit boundary of the abort rule, the go-ahead pattern, and where enable and disable take effect relative to the frame. It also includes the different overflow handling in protocol and transparent modes.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  typedef enum logic [1:0] {
    FS_OFF  = 2'd0,
    FS_HUNT = 2'd1,
    FS_OPEN = 2'd2,
    FS_DATA = 2'd3
  } fstate_t;

  typedef enum logic [1:0] {
    EK_CLEAN = 2'd0,
    EK_ABORT = 2'd1,
    EK_SHORT = 2'd2
  } end_kind_t;
endpackage

// File: rtl/hdlc_rx_linemon.sv
module hdlc_rx_linemon #(
  parameter int FLAG_ONES  = 6,
  parameter int ABORT_ONES = 7,
  parameter int IDLE_ONES  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_i,
  output logic ev_flag,
  output logic ev_abort,
  output logic ev_stuff,
  output logic ev_goahead,
  output logic line_idle
);
  localparam int OW = $clog2(IDLE_ONES + 1);
  localparam int HW = ABORT_ONES + 2;
  localparam logic [HW-1:0] GA_PAT = {1'b0, {ABORT_ONES{1'b1}}, 1'b0};
  localparam logic [OW-1:0] ONES_MAX = OW'(IDLE_ONES);

  logic [OW-1:0] ones_q;
  logic [HW-1:0] hist_q;
  logic [HW-1:0] hist_n;

  assign hist_n     = {hist_q[HW-2:0], bit_i};
  assign ev_stuff   = bit_en && !bit_i && (ones_q == OW'(FLAG_ONES - 1));
  assign ev_flag    = bit_en && !bit_i && (ones_q == OW'(FLAG_ONES));
  assign ev_abort   = bit_en &&  bit_i && (ones_q == OW'(ABORT_ONES - 1));
  assign ev_goahead = bit_en && (hist_n == GA_PAT);
  assign line_idle  = (ones_q == ONES_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q <= '0;
      hist_q <= '1;
    end else if (bit_en) begin
      hist_q <= hist_n;
      if (!bit_i)                  ones_q <= '0;
      else if (ones_q != ONES_MAX) ones_q <= ones_q + 1'b1;
    end
  end

  // R7
  idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_idle) |-> $past(bit_en && bit_i));
endmodule

// File: rtl/hdlc_rx_delay.sv
module hdlc_rx_delay #(
  parameter int DEPTH = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic bit_i,
  output logic dlv,
  output logic dlv_bit
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] pd_q;
  logic [CW-1:0]    cnt_q;
  logic             full;

  assign full    = (cnt_q == CW'(DEPTH));
  assign dlv     = push && full;
  assign dlv_bit = pd_q[DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (push) begin
      pd_q <= {pd_q[DEPTH-2:0], bit_i};
      if (!full) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rx_slot.sv
module hdlc_rx_slot #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         overwrite_ok,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         accept,
  output logic         ovf
);
  logic can_take;
  logic replace;

  assign can_take = !out_valid || out_ready;
  assign accept   = wr && can_take;
  assign ovf      = wr && !can_take;
  assign replace  = ovf && overwrite_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (accept || replace) begin
        out_valid <= 1'b1;
        out_data  <= wr_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R10
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
  // R10
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !replace |=> $stable(out_data));
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int DW             = 8,
  parameter int FLAG_ONES      = 6,
  parameter int ABORT_ONES     = 7,
  parameter int IDLE_ONES      = 15,
  parameter int MIN_ABORT_BITS = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enable,
  input  logic          transparent,
  input  logic          line_bit,
  input  logic          line_bit_en,
  output logic          item_valid,
  input  logic          item_ready,
  output logic [DW-1:0] item_data,
  output logic          item_eop,
  output logic [1:0]    item_kind,
  output logic          flag_pulse,
  output logic          goahead_pulse,
  output logic          abort_pulse,
  output logic          eopd_pulse,
  output logic          overflow_pulse,
  output logic          line_idle
);
  localparam int DELAY   = FLAG_ONES + 1;
  localparam int FA_BITS = MIN_ABORT_BITS + FLAG_ONES;
  localparam int FBW     = $clog2(FA_BITS + 1);
  localparam int BCW     = $clog2(DW);
  localparam int IW      = DW + 3;

  logic ev_flag, ev_abort, ev_stuff, ev_ga;
  fstate_t        st_q;
  logic           trans_q;
  logic [FBW-1:0] fbits_q;
  logic [BCW-1:0] bcnt_q;
  logic [DW-1:0]  sr_q;
  logic           byte_wr_q;

  hdlc_rx_linemon #(
    .FLAG_ONES(FLAG_ONES), .ABORT_ONES(ABORT_ONES), .IDLE_ONES(IDLE_ONES)
  ) u_mon (
    .clk(clk), .rst_n(rst_n), .bit_en(line_bit_en), .bit_i(line_bit),
    .ev_flag(ev_flag), .ev_abort(ev_abort), .ev_stuff(ev_stuff),
    .ev_goahead(ev_ga), .line_idle(line_idle)
  );

  logic active, proto, in_frame, en_drop, mode_chg, hold;
  logic push, dly_clr, dlv, dlv_bit;

  assign active   = (st_q != FS_OFF);
  assign proto    = active && !trans_q;
  assign in_frame = (st_q == FS_OPEN) || (st_q == FS_DATA);
  assign en_drop  = active && !rx_enable && !((st_q == FS_DATA) && byte_wr_q);
  assign mode_chg = active && (transparent != trans_q);
  assign hold     = en_drop || mode_chg;
  assign push     = proto && in_frame && line_bit_en && !hold &&
                    !ev_flag && !ev_abort && !ev_stuff;
  assign dly_clr  = !proto || !in_frame || hold || ev_flag || ev_abort;

  hdlc_rx_delay #(.DEPTH(DELAY)) u_dly (
    .clk(clk), .rst_n(rst_n), .clr(dly_clr), .push(push),
    .bit_i(line_bit), .dlv(dlv), .dlv_bit(dlv_bit)
  );

  logic          asm_step, asm_bit, byte_done, close_any;
  logic [DW-1:0] byte_val;
  end_kind_t     kind;
  logic          wr, acc, ovf, restart;
  logic [IW-1:0] wr_item, slot_q;

  assign asm_step  = (active && trans_q && line_bit_en && !hold) || dlv;
  assign asm_bit   = trans_q ? line_bit : dlv_bit;
  assign byte_val  = {asm_bit, sr_q[DW-1:1]};
  assign byte_done = asm_step && (bcnt_q == BCW'(DW - 1));
  assign close_any = proto && !hold && (st_q == FS_DATA) && (ev_flag || ev_abort);

  always_comb begin
    if (ev_abort)              kind = EK_ABORT;
    else if (bcnt_q != '0)     kind = EK_SHORT;
    else                       kind = EK_CLEAN;
  end

  assign wr      = byte_done || close_any;
  assign wr_item = close_any ? {1'b1, kind, {DW{1'b0}}} : {1'b0, 2'b00, byte_val};
  assign restart = !active || hold || (proto && (ev_flag || ev_abort || ovf));

  hdlc_rx_slot #(.W(IW)) u_slot (
    .clk(clk), .rst_n(rst_n), .wr(wr), .wr_data(wr_item),
    .overwrite_ok(trans_q), .out_ready(item_ready), .out_valid(item_valid),
    .out_data(slot_q), .accept(acc), .ovf(ovf)
  );

  assign item_eop  = slot_q[IW-1];
  assign item_kind = slot_q[IW-2:IW-3];
  assign item_data = slot_q[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q           <= FS_OFF;
      trans_q        <= 1'b0;
      fbits_q        <= '0;
      bcnt_q         <= '0;
      sr_q           <= '0;
      byte_wr_q      <= 1'b0;
      flag_pulse     <= 1'b0;
      goahead_pulse  <= 1'b0;
      abort_pulse    <= 1'b0;
      eopd_pulse     <= 1'b0;
      overflow_pulse <= 1'b0;
    end else begin
      flag_pulse     <= proto && !hold && ev_flag;
      goahead_pulse  <= proto && !hold && ev_ga;
      eopd_pulse     <= close_any && acc;
      abort_pulse    <= close_any && acc && ev_abort && (fbits_q == FBW'(FA_BITS));
      overflow_pulse <= ovf;

      if (asm_step) sr_q <= byte_val;
      if (restart) begin
        fbits_q   <= '0;
        bcnt_q    <= '0;
        byte_wr_q <= 1'b0;
      end else begin
        if (asm_step) bcnt_q <= byte_done ? '0 : bcnt_q + 1'b1;
        if (push && fbits_q != FBW'(FA_BITS)) fbits_q <= fbits_q + 1'b1;
        if (byte_done && acc) byte_wr_q <= 1'b1;
      end

      if (!active) begin
        if (rx_enable) st_q <= FS_HUNT;
        trans_q <= transparent;
      end else if (en_drop) begin
        st_q <= FS_OFF;
      end else if (mode_chg) begin
        st_q    <= FS_HUNT;
        trans_q <= transparent;
      end else if (!trans_q) begin
        if (ovf)           st_q <= FS_HUNT;
        else if (ev_flag)  st_q <= FS_OPEN;
        else if (ev_abort) st_q <= FS_HUNT;
        else if (dlv)      st_q <= FS_DATA;
      end
    end
  end

  // R3
  eopd_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eopd_pulse |-> item_valid && item_eop && item_data == '0);
  // R5
  abort_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> eopd_pulse && item_kind == 2'd1);
  // R11
  ovf_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_pulse |-> item_valid);
  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == FS_OFF |=> !eopd_pulse && !flag_pulse);
endmodule

// File: tb/hdlc_rx_deframer_bench.sv
module hdlc_rx_deframer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_enable = 1'b0;
  logic       transparent = 1'b0;
  logic       line_bit = 1'b1;
  logic       line_bit_en = 1'b0;
  logic       item_ready = 1'b1;
  logic       item_valid, item_eop;
  logic [7:0] item_data;
  logic [1:0] item_kind;
  logic       flag_pulse, goahead_pulse, abort_pulse, eopd_pulse, overflow_pulse, line_idle;

  always #4 clk = ~clk;

  hdlc_rx_deframer u_hdlc_rx_deframer (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .transparent(transparent),
    .line_bit(line_bit), .line_bit_en(line_bit_en), .item_valid(item_valid),
    .item_ready(item_ready), .item_data(item_data), .item_eop(item_eop),
    .item_kind(item_kind), .flag_pulse(flag_pulse), .goahead_pulse(goahead_pulse),
    .abort_pulse(abort_pulse), .eopd_pulse(eopd_pulse),
    .overflow_pulse(overflow_pulse), .line_idle(line_idle)
  );

  int nchk = 0, nfail = 0, tx_ones = 0;
  int c_flag = 0, c_ga = 0, c_fa = 0, c_eopd = 0, c_ovf = 0;
  bit done = 1'b0;
  logic [10:0] exp_q[$];
  string       req_q[$];

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (flag_pulse) c_flag++;
      if (goahead_pulse) c_ga++;
      if (abort_pulse) c_fa++;
      if (eopd_pulse) c_eopd++;
      if (overflow_pulse) c_ovf++;
      if (item_valid && item_ready) begin
        if (exp_q.size() == 0) chk("R10 unexpected item", {item_eop, item_kind, item_data}, 0);
        else chk(req_q.pop_front(), {item_eop, item_kind, item_data}, exp_q.pop_front());
      end
    end
  end

  task automatic expect_item(input logic e, input logic [1:0] k, input logic [7:0] d, input string r);
    exp_q.push_back({e, k, d});
    req_q.push_back(r);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); line_bit = b; line_bit_en = 1'b1;
    @(negedge clk); line_bit_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_data_bit(input logic b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_bit(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic send_abort();
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp, input string r);
    if (exp) expect_item(1'b0, 2'b00, b, r);
    for (int i = 0; i < 8; i++) send_data_bit(b[i]);
  endtask

  task automatic send_raw_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #1 item_ready = v;
  endtask

  task automatic settle(input string r);
    repeat (12) @(negedge clk);
    chk(r, exp_q.size(), 0);
  endtask

  initial begin
    int f0, g0, a0, e0, o0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 item_valid", item_valid, 0);
    chk("R1 pulses", {flag_pulse, goahead_pulse, abort_pulse, eopd_pulse, overflow_pulse}, 0);
    chk("R1 line_idle", line_idle, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {item_valid, line_idle, flag_pulse, eopd_pulse}, 0);

    // R8 bytes before any flag are ignored; R2 R3 clean frame with stuffing
    rx_enable = 1'b1;
    f0 = c_flag; e0 = c_eopd;
    send_byte(8'h12, 0, "");
    send_byte(8'h34, 0, "");
    settle("R8 no item before flag");
    send_flag();
    send_byte(8'hFF, 1, "R2 byte FF");
    send_byte(8'h7E, 1, "R2 byte 7E");
    send_byte(8'h81, 1, "R2 byte 81");
    expect_item(1'b1, 2'b00, 8'h00, "R3 clean end");
    send_flag();
    settle("R3 queue drained");
    chk("R2 flag count", c_flag - f0, 2);
    chk("R3 eopd count", c_eopd - e0, 1);

    // R8 enable in the middle of a packet
    rx_enable = 1'b0;
    f0 = c_flag;
    send_flag();
    send_byte(8'h55, 0, "");
    rx_enable = 1'b1;
    send_byte(8'h66, 0, "");
    send_flag();
    send_byte(8'h0F, 1, "R8 byte after flag");
    expect_item(1'b1, 2'b00, 8'h00, "R8 end");
    send_flag();
    settle("R8 drained");
    chk("R8 flag count", c_flag - f0, 2);

    // R4 partial byte at close
    send_byte(8'hA5, 1, "R4 byte A5");
    send_byte(8'h3C, 1, "R4 byte 3C");
    send_data_bit(1'b1); send_data_bit(1'b0); send_data_bit(1'b1);
    expect_item(1'b1, 2'b10, 8'h00, "R4 short end");
    send_flag();
    settle("R4 drained");

    // R5 abort with 25 bits: no frame-abort pulse
    a0 = c_fa; e0 = c_eopd;
    send_byte(8'h11, 1, "R5 byte 11");
    send_byte(8'h22, 1, "R5 byte 22");
    send_byte(8'h33, 1, "R5 byte 33");
    send_data_bit(1'b0);
    expect_item(1'b1, 2'b01, 8'h00, "R5 abort end 25");
    send_abort();
    settle("R5 drained 25");
    chk("R5 no pulse at 25 bits", c_fa - a0, 0);
    chk("R5 eopd at 25 bits", c_eopd - e0, 1);
    // R5 abort with 26 bits: pulse
    send_flag();
    a0 = c_fa;
    send_byte(8'h11, 1, "R5 byte 11b");
    send_byte(8'h22, 1, "R5 byte 22b");
    send_byte(8'h33, 1, "R5 byte 33b");
    send_data_bit(1'b0); send_data_bit(1'b0);
    expect_item(1'b1, 2'b01, 8'h00, "R5 abort end 26");
    send_abort();
    settle("R5 drained 26");
    chk("R5 pulse at 26 bits", c_fa - a0, 1);

    // R6 go-ahead after a flag
    send_flag();
    g0 = c_ga; e0 = c_eopd;
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    send_bit(1'b0);
    settle("R6 no item");
    chk("R6 goahead count", c_ga - g0, 1);
    chk("R6 no eopd", c_eopd - e0, 0);

    // R7 idle
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    chk("R7 idle after 14", line_idle, 0);
    send_bit(1'b1);
    chk("R7 idle after 15", line_idle, 1);
    send_bit(1'b0);
    chk("R7 idle cleared", line_idle, 0);
    send_flag();

    // R9 disable after a byte written: frame completes
    send_byte(8'hC1, 1, "R9 byte C1");
    send_byte(8'hC2, 1, "R9 byte C2");
    send_byte(8'hC3, 1, "R9 byte C3");
    rx_enable = 1'b0;
    send_byte(8'hC4, 1, "R9 byte C4");
    expect_item(1'b1, 2'b00, 8'h00, "R9 end");
    send_flag();
    settle("R9 frame completed");
    f0 = c_flag;
    send_byte(8'hD1, 0, "");
    send_flag();
    settle("R9 stopped no item");
    chk("R9 stopped no flag", c_flag - f0, 0);
    // R9 disable before any byte written: immediate
    rx_enable = 1'b1;
    send_flag();
    send_byte(8'hE1, 0, "");
    rx_enable = 1'b0;
    send_byte(8'hE2, 0, "");
    send_flag();
    settle("R9 early stop no item");
    rx_enable = 1'b1;
    send_flag();

    // R11 overflow in protocol mode
    o0 = c_ovf; e0 = c_eopd;
    set_ready(1'b0);
    send_byte(8'hC3, 1, "R11 held byte");
    send_byte(8'h99, 0, "");
    send_flag();
    repeat (4) @(negedge clk);
    chk("R10 valid held", item_valid, 1);
    chk("R10 data held", item_data, 8'hC3);
    set_ready(1'b1);
    settle("R11 held item only");
    chk("R11 overflow count", c_ovf - o0, 1);
    chk("R11 no end item", c_eopd - e0, 0);
    send_byte(8'h5A, 1, "R11 recovery byte");
    expect_item(1'b1, 2'b00, 8'h00, "R11 recovery end");
    send_flag();
    settle("R11 recovered");

    // R12 transparent mode
    f0 = c_flag; o0 = c_ovf;
    transparent = 1'b1;
    repeat (2) @(negedge clk);
    expect_item(1'b0, 2'b00, 8'h7E, "R12 raw 7E");
    send_raw_byte(8'h7E);
    expect_item(1'b0, 2'b00, 8'hFF, "R12 raw FF");
    send_raw_byte(8'hFF);
    settle("R12 raw drained");
    chk("R12 no flag pulse", c_flag - f0, 0);
    set_ready(1'b0);
    send_raw_byte(8'h01);
    send_raw_byte(8'h02);
    send_raw_byte(8'h03);
    repeat (3) @(negedge clk);
    chk("R12 overwritten byte", item_data, 8'h03);
    expect_item(1'b0, 2'b00, 8'h03, "R12 last byte");
    set_ready(1'b1);
    settle("R12 overwrite drained");
    chk("R12 overflow count", c_ovf - o0, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule